// File: doc/BRIEF.md
# Lane-Shared FIR Filter

This block filters a stream of 16-bit signed audio samples with a long finite impulse response. The samples arrive far more slowly than the system clock runs, so a small bank of multipliers is reused many times for each sample. Each multiplier is called a lane. A sample accepted on the input enters a delay line. A controller then walks that line together with the coefficient vector, a fixed group of taps per clock. It adds the products of each group into a wide accumulator. When the last group is done, it publishes one scaled, saturated result.

The coefficients come in on a port as a flat vector, so they can be held constant or reloaded between samples. The user sets the lane count, the tap count and the output scaling shift with parameters. The upstream stage must not offer a new sample while a computation is in progress. Such a sample is dropped. A normal source waits for the output strobe, which the low sample rate makes easy.

Top module: `tmfir_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears `out_sample` to 0, drops `out_valid`, empties the delay line and returns the controller to idle. The first result after reset therefore sees an all-zero sample history.
- R2: Each result equals the direct-form sum over k of h[k]·x[n−k], before scaling. Here h[k] is coefficient k, taken from `coeffs` bits [18k+17:18k] as 18-bit two's complement. x[n−k] is the k-th most recent accepted sample, and x[0] is the newest.
- R3: The result is the full-precision sum shifted right arithmetically by `OUT_SHIFT` (17 by default). It is then clamped to the range −32768 to 32767.
- R4: `out_valid` rises exactly `NUM_TAPS/PARALLELISM + 1` rising edges after the edge that accepts a sample. With the defaults that is 33 edges. It stays high for one cycle only.
- R5: `out_sample` changes only in a cycle where `out_valid` is high. It holds its value at all other times.
- R6: A high `in_valid` while a computation is in progress is ignored. The sample does not enter the delay line and has no effect on any later result.
- R7: The accumulator starts from zero for every accepted sample. A result depends only on the sample history and the coefficients, never on earlier sums.
- R8: At step s, lane l multiplies the sample of age s·PARALLELISM + l with the coefficient of the same index. Every tap 0 … NUM_TAPS−1 therefore contributes exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Offers `in_sample`; taken only when idle |
| in_sample | input | 16 | New signed input sample |
| coeffs | input | NUM_TAPS*18 | Flat coefficient vector, tap k at bits [18k+17:18k] |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_sample | output | 16 | Scaled, saturated filter output |

## Verification
Several internal faults show up at the ports in recognisable ways. A stale accumulator or a wrong lane-to-tap mapping corrupts the very next result. That fault appears on the first `out_valid` after the sample that exposes it, 33 edges after acceptance. The impulse response makes any misplaced tap visible as a single wrong output at that tap's delay. A delay line that shifts during a computation appears one sample later, as a result that includes a value the source never sent. A controller that counts the wrong number of steps moves the strobe away from its fixed latency. It also drops or doubles the contribution of a whole lane group.

// File: rtl/tmfir_pkg.sv
// Shared definitions for the lane-shared FIR filter.
// Assumes two's complement signed data throughout.
package tmfir_pkg;

    localparam int SAMPLE_W = 16;   // input and output sample width
    localparam int COEF_W   = 18;   // coefficient and widened sample width
    localparam int PROD_W   = 2 * COEF_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_DONE = 2'd2
    } fir_state_e;

endpackage

// File: rtl/tmfir_delay_line.sv
// Sample history register for the FIR filter.
// Holds DEPTH samples; slot 0 is the newest. On shift_en every slot moves
// one place toward higher indices and din enters slot 0.
// Assumes the caller asserts shift_en only when a sample is accepted.
module tmfir_delay_line #(
    parameter int DEPTH = 256,
    parameter int W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic signed [W-1:0]  din,
    output logic [DEPTH*W-1:0]   taps_flat
);

    logic signed [W-1:0] slot [DEPTH];

    // Shift the history by one on each accepted sample; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
        end else if (shift_en) begin
            slot[0] <= din;
            for (int i = 1; i < DEPTH; i++) slot[i] <= slot[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_flat
            assign taps_flat[g*W +: W] = slot[g];
        end
    endgenerate

endmodule

// File: rtl/tmfir_mac_lanes.sv
// Multiplier bank and unrolled lane adder.
// For step index `step`, lane l reads history slot and coefficient
// step*LANES + l, widens the sample to COEF_W bits at the read, multiplies,
// and all lane products are summed into psum (ACC_W bits).
// Assumes ACC_W >= PROD_W, so every product fits without loss.
module tmfir_mac_lanes
    import tmfir_pkg::*;
#(
    parameter int TAPS   = 256,
    parameter int LANES  = 8,
    parameter int STEP_W = 5,
    parameter int ACC_W  = 42
) (
    input  logic [TAPS*SAMPLE_W-1:0]   taps_flat,
    input  logic [TAPS*COEF_W-1:0]     coeffs_flat,
    input  logic [STEP_W-1:0]          step,
    output logic signed [ACC_W-1:0]    psum
);

    logic signed [PROD_W-1:0] prod [LANES];

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            logic signed [SAMPLE_W-1:0] smp;
            logic signed [COEF_W-1:0]   smp_wide;
            logic signed [COEF_W-1:0]   cof;
            int unsigned                idx;

            // Select this lane's tap and widen the sample at the read.
            always_comb begin
                idx      = int'(step) * LANES + l;
                smp      = taps_flat[idx*SAMPLE_W +: SAMPLE_W];
                cof      = coeffs_flat[idx*COEF_W +: COEF_W];
                smp_wide = {{(COEF_W-SAMPLE_W){smp[SAMPLE_W-1]}}, smp};
                prod[l]  = smp_wide * cof;
            end
        end
    endgenerate

    // Unrolled sum of all lane products, each sign-extended to ACC_W.
    always_comb begin
        psum = '0;
        for (int i = 0; i < LANES; i++) begin
            psum = psum + {{(ACC_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
        end
    end

endmodule

// File: rtl/tmfir_ctrl.sv
// Sequencer for one filter computation.
// Waits in idle for in_valid, then runs STEPS multiply-accumulate cycles,
// passes one cycle in done, and goes back to idle. in_valid outside idle
// is not looked at.
module tmfir_ctrl
    import tmfir_pkg::*;
#(
    parameter int STEPS  = 32,
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              accept,
    output logic              acc_en,
    output logic              load,
    output logic [STEP_W-1:0] step,
    output fir_state_e        state
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    fir_state_e state_q;
    logic [STEP_W-1:0] step_q;

    // Advance the state machine and the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    step_q <= '0;
                    if (in_valid) state_q <= ST_MAC;
                end
                ST_MAC: begin
                    if (step_q == LAST_STEP) begin
                        state_q <= ST_DONE;
                        step_q  <= '0;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode the controls for the delay line, accumulator and output.
    always_comb begin
        accept = (state_q == ST_IDLE) && in_valid;
        acc_en = (state_q == ST_MAC);
        load   = (state_q == ST_DONE);
    end

    assign step  = step_q;
    assign state = state_q;

endmodule

// File: rtl/tmfir_out_stage.sv
// Accumulator, scaler and saturating output register.
// Clears on clr, adds psum on acc_en, and on load shifts the sum right by
// SHIFT (arithmetic), clamps it to SAMPLE_W bits and pulses out_valid.
// Assumes clr and acc_en never coincide (guaranteed by the sequencer).
module tmfir_out_stage
    import tmfir_pkg::*;
#(
    parameter int ACC_W = 42,
    parameter int SHIFT = 17
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        acc_en,
    input  logic                        load,
    input  logic signed [ACC_W-1:0]     psum,
    output logic                        out_valid,
    output logic signed [SAMPLE_W-1:0]  out_sample
);

    logic signed [ACC_W-1:0]          acc_q;
    logic signed [ACC_W-1:0]          scaled;
    logic [ACC_W-SAMPLE_W:0]          head;
    logic signed [SAMPLE_W-1:0]       clamped;

    // Running sum: cleared per sample, one lane group added per step.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (clr)    acc_q <= '0;
        else if (acc_en) acc_q <= acc_q + psum;
    end

    // Scale the finished sum and clamp it into the output range.
    always_comb begin
        scaled = acc_q >>> SHIFT;
        head   = scaled[ACC_W-1:SAMPLE_W-1];
        if (head == '0 || head == '1)
            clamped = scaled[SAMPLE_W-1:0];
        else if (scaled[ACC_W-1])
            clamped = {1'b1, {(SAMPLE_W-1){1'b0}}};
        else
            clamped = {1'b0, {(SAMPLE_W-1){1'b1}}};
    end

    // Publish the result and its one-cycle strobe only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= load;
            if (load) out_sample <= clamped;
        end
    end

endmodule

// File: rtl/tmfir_top.sv
// Lane-shared FIR filter top.
// Accepts a sample when idle, runs NUM_TAPS/PARALLELISM accumulate steps
// with PARALLELISM multipliers, then outputs the scaled, saturated sum.
// Assumes NUM_TAPS is a multiple of PARALLELISM, NUM_TAPS >= 4, and
// NUM_TAPS/PARALLELISM >= 2.
module tmfir_top
    import tmfir_pkg::*;
#(
    parameter int PARALLELISM = 8,
    parameter int NUM_TAPS    = 256,
    parameter int OUT_SHIFT   = 17
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic signed [15:0]          in_sample,
    input  logic [NUM_TAPS*18-1:0]      coeffs,
    output logic                        out_valid,
    output logic signed [15:0]          out_sample
);

    localparam int STEPS  = NUM_TAPS / PARALLELISM;
    localparam int STEP_W = $clog2(STEPS);
    localparam int ACC_W  = SAMPLE_W + COEF_W + $clog2(NUM_TAPS);

    logic                           accept;
    logic                           acc_en;
    logic                           load;
    logic [STEP_W-1:0]              step;
    fir_state_e                     state;
    logic [NUM_TAPS*SAMPLE_W-1:0]   taps_flat;
    logic signed [ACC_W-1:0]        psum;
    logic signed [SAMPLE_W-1:0]     newest_sample;

    tmfir_ctrl #(
        .STEPS  (STEPS),
        .STEP_W (STEP_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .accept   (accept),
        .acc_en   (acc_en),
        .load     (load),
        .step     (step),
        .state    (state)
    );

    tmfir_delay_line #(
        .DEPTH (NUM_TAPS),
        .W     (SAMPLE_W)
    ) hist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (accept),
        .din       (in_sample),
        .taps_flat (taps_flat)
    );

    tmfir_mac_lanes #(
        .TAPS   (NUM_TAPS),
        .LANES  (PARALLELISM),
        .STEP_W (STEP_W),
        .ACC_W  (ACC_W)
    ) lanes_i (
        .taps_flat   (taps_flat),
        .coeffs_flat (coeffs),
        .step        (step),
        .psum        (psum)
    );

    tmfir_out_stage #(
        .ACC_W (ACC_W),
        .SHIFT (OUT_SHIFT)
    ) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (accept),
        .acc_en     (acc_en),
        .load       (load),
        .psum       (psum),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    assign newest_sample = taps_flat[SAMPLE_W-1:0];

endmodule

// File: rtl/tmfir_checker.sv
// Protocol and timing properties of the lane-shared FIR filter.
// Bound to tmfir_top; watches the ports plus the sequencer state and the
// newest history slot. The latency window is measured with a counter.
module tmfir_checker
    import tmfir_pkg::*;
#(
    parameter int NUM_TAPS    = 256,
    parameter int PARALLELISM = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       out_valid,
    input  logic signed [SAMPLE_W-1:0] out_sample,
    input  fir_state_e                 state,
    input  logic signed [SAMPLE_W-1:0] newest
);

    localparam int STEPS = NUM_TAPS / PARALLELISM;

    logic [15:0] lat_cnt;

    // Count edges since the last accepted sample; idle at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                              lat_cnt <= '0;
        else if (in_valid && state == ST_IDLE)   lat_cnt <= 16'd1;
        else if (out_valid)                      lat_cnt <= '0;
        else if (lat_cnt != '0)                  lat_cnt <= lat_cnt + 16'd1;
    end

    p_pulse_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lat_cnt == 16'(STEPS + 2)));

    p_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(state) == ST_DONE));

    p_hold_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample));

    p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(newest));

endmodule

bind tmfir_top tmfir_checker #(
    .NUM_TAPS    (NUM_TAPS),
    .PARALLELISM (PARALLELISM)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .state      (state),
    .newest     (newest_sample)
);

// File: tb/tmfir_top_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench for tmfir_top: impulse, steps, saturation, random
// data, busy-time pokes and a mid-run reset, against a direct-form model.
module tmfir_top_tb_top;

    localparam int P     = 8;
    localparam int N     = 256;
    localparam int SHIFT = 17;
    localparam int STEPS = N / P;
    localparam real CLK_NS = 4.0;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic signed [15:0]    in_sample = '0;
    logic [N*18-1:0]       coeffs = '0;
    logic                  out_valid;
    logic signed [15:0]    out_sample;

    int checks = 0;
    int errors = 0;
    longint hist [N];
    longint coef [N];

    always #(CLK_NS/2) clk = ~clk;

    tmfir_top #(.PARALLELISM(P), .NUM_TAPS(N), .OUT_SHIFT(SHIFT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .coeffs(coeffs), .out_valid(out_valid), .out_sample(out_sample)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model_out();
        longint acc = 0;
        for (int k = 0; k < N; k++) acc += hist[k] * coef[k];
        acc = acc >>> SHIFT;
        if (acc > 32767) return 32767;
        if (acc < -32768) return -32768;
        return acc;
    endfunction

    task automatic load_coef();
        for (int k = 0; k < N; k++) coeffs[k*18 +: 18] = coef[k][17:0];
    endtask

    task automatic clear_hist();
        for (int k = 0; k < N; k++) hist[k] = 0;
    endtask

    // Drive one sample, optionally poke in_valid while busy, then check
    // latency, hold, value and strobe width.
    task automatic run_sample(input longint x, input bit poke, input string req);
        longint exp_v;
        int cyc;
        bit held;
        logic signed [15:0] prev;
        @(negedge clk);
        prev = out_sample;
        in_sample = 16'(x);
        in_valid = 1'b1;
        for (int k = N-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        exp_v = model_out();
        @(negedge clk);
        in_valid = 1'b0;
        cyc = 0;
        held = 1'b1;
        while (!out_valid && cyc < 200) begin
            if (out_sample != prev) held = 1'b0;
            @(negedge clk);
            cyc++;
            if (poke && cyc == 3) begin
                in_sample = 16'sh5A5A;
                in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        in_valid = 1'b0;
        check(out_valid, "R4 strobe missing", cyc, STEPS + 1);
        check(cyc == STEPS + 1, "R4 latency", cyc, STEPS + 1);
        check(held, "R5 output changed without strobe", 0, 1);
        check(longint'(out_sample) == exp_v, req, out_sample, exp_v);
        @(negedge clk);
        check(!out_valid, "R4 strobe longer than one cycle", out_valid, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_sample == 0, "R1 reset output", out_sample, 0);
        check(!out_valid, "R1 reset strobe", out_valid, 0);
        rst_n = 1'b1;
        clear_hist();
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // Distinct coefficients expose any lane/step mapping slip (R8).
        for (int k = 0; k < N; k++) coef[k] = longint'($urandom_range(0, 262143)) - 131072;
        load_coef();
        do_reset();
        // Impulse: first output sees cleared history (R1), rest trace h[k] (R8, R2).
        run_sample(32767, 1'b0, "R1 first result after reset");
        for (int i = 0; i < 40; i++) run_sample(0, 1'b0, "R8 impulse tap mapping");

        // Random data with busy-time pokes that must not enter the history (R6).
        for (int i = 0; i < 120; i++)
            run_sample(longint'($urandom_range(0, 65535)) - 32768, (i % 4) == 1, "R6 R2 random data");

        // Moderate step response with small coefficients (R2, R7).
        for (int k = 0; k < N; k++) coef[k] = longint'($urandom_range(0, 4000)) - 2000;
        load_coef();
        for (int i = 0; i < 30; i++) run_sample(32767, 1'b0, "R7 step response");
        // Repeated identical zero input after a step: sums must not carry (R7).
        for (int i = 0; i < 10; i++) run_sample(0, 1'b0, "R7 fresh accumulator");

        // Large coefficients drive the sum past both clamps (R3).
        for (int k = 0; k < N; k++) coef[k] = 131071;
        load_coef();
        for (int i = 0; i < 12; i++) run_sample(32767, 1'b0, "R3 clamp high");
        for (int i = 0; i < 12; i++) run_sample(-32768, 1'b0, "R3 clamp low");
        for (int k = 0; k < N; k++) coef[k] = -131072;
        load_coef();
        for (int i = 0; i < 6; i++) run_sample(-32768, 1'b0, "R3 clamp high from negatives");

        // Mid-run reset empties the history again (R1).
        do_reset();
        for (int k = 0; k < N; k++) coef[k] = longint'($urandom_range(0, 262143)) - 131072;
        load_coef();
        run_sample(-12345, 1'b1, "R1 history cleared by reset");
        run_sample(23456, 1'b0, "R2 after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule